// File: doc/BRIEF.md
# Read-After-Deallocate Return Masking

This block sits on the host read path of a block-storage controller. It sits after the logical-to-physical lookup and before the data goes back to the host. It keeps one deallocated flag per logical block. A trim request sets the flag for its address, and a write to that address clears it again. Each read beat arrives with its logical address and the data the storage lookup produced. If the address is flagged, the block replaces that data according to the configured return mode. Otherwise the data passes through unchanged.

Three return behaviours are supported: all zeros, a fixed programmable pattern, or the stored data unmodified. The stored data may still be stale, since physical erase happens elsewhere and later. Masking is decided purely from the flag. It never depends on what the storage still holds. A 3-bit mode field and a data pattern are loaded through a configuration write, and the mode can be read back. Every read takes exactly one cycle, whether it is masked or not, so responses leave in request order.

Top module: `rad_return_mask`

## Requirements
- R1: After reset, the mode readback is 001b, the response valid is low, and no address is flagged, so reads return their input data.
- R2: Each read beat produces a response exactly one cycle later. The response valid follows the request valid one cycle later, and back-to-back reads return in request order.
- R3: A read of an address that is not flagged returns its input data unchanged, in every mode.
- R4: A trim sets the flag of its address at the next clock edge. A read presented in any later cycle sees the flag.
- R5: With mode 001b, a read of a flagged address returns all zeros, whatever the input data holds.
- R6: With mode 010b, a read of a flagged address returns the configured pattern. Repeated reads of the same address return identical data even when the input data differs.
- R7: With mode 000b, a read of a flagged address returns the input data unmodified.
- R8: Modes 011b to 111b are reserved and behave like 000b.
- R9: A write to a flagged address clears its flag, so later reads return the input data.
- R10: When a trim and a write name the same address in the same cycle, the write wins and the flag ends up clear.
- R11: A configuration write loads the mode and the pattern. The mode readback shows the new 3-bit value from the next cycle on.
- R12: A trim or write to one address leaves the flags of all other addresses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load mode and pattern |
| cfg_mode_in | input | 3 | New return mode |
| cfg_pattern_in | input | DATA_W | New fill pattern |
| mode_rd | output | 3 | Mode readback |
| trim_valid | input | 1 | Trim request |
| trim_addr | input | ADDR_W | Logical block to flag |
| wr_valid | input | 1 | Write notification |
| wr_addr | input | ADDR_W | Logical block to unflag |
| rd_in_valid | input | 1 | Read beat valid |
| rd_in_addr | input | ADDR_W | Read logical block |
| rd_in_data | input | DATA_W | Data from storage lookup |
| rd_out_valid | output | 1 | Response valid |
| rd_out_data | output | DATA_W | Response data |

## Verification
On every cycle, the assertions check four things:
- the fixed one-cycle latency;
- pass-through for unflagged reads;
- zero and pattern substitution for flagged reads;
- flag setting by trim and the write-over-trim priority.

Some behaviours only the bench scenarios can show. These are that repeated pattern reads stay identical while the input data changes, and that reserved modes behave like the no-guarantee mode. They also include that a trim leaves neighbouring addresses alone and that a write reopens an address. The bench additionally covers the extreme addresses 0 and 63.

// File: rtl/rad_pkg.sv
package rad_pkg;
    typedef enum logic [2:0] {
        RM_NONE    = 3'b000,
        RM_ZERO    = 3'b001,
        RM_PATTERN = 3'b010
    } ret_mode_e;
endpackage

// File: rtl/rad_flag_table.sv
module rad_flag_table #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trim_valid,
    input  logic [ADDR_W-1:0] trim_addr,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_flag
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] flags_d, flags_q;

    // Per-entry next value; a write is applied after the trim so it wins.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_comb begin
            flags_d[i] = flags_q[i];
            if (trim_valid && (trim_addr == ADDR_W'(i))) flags_d[i] = 1'b1;
            if (wr_valid && (wr_addr == ADDR_W'(i)))     flags_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign look_flag = flags_q[look_addr];

    // R4: an uncontested trim leaves its address flagged
    a_r4_trim_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_valid && !(wr_valid && wr_addr == trim_addr)) |=> flags_q[$past(trim_addr)]);

    // R9/R10: any write leaves its address clear, even against a trim
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !flags_q[$past(wr_addr)]);
endmodule

// File: rtl/rad_fill_select.sv
module rad_fill_select
    import rad_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        mode,
    input  logic              flagged,
    input  logic [DATA_W-1:0] raw_data,
    input  logic [DATA_W-1:0] pattern,
    output logic [DATA_W-1:0] ret_data
);
    always_comb begin
        ret_data = raw_data;
        if (flagged) begin
            unique case (mode)
                RM_ZERO:    ret_data = '0;
                RM_PATTERN: ret_data = pattern;
                default:    ret_data = raw_data; // none and reserved codes
            endcase
        end
    end
endmodule

// File: rtl/rad_return_mask.sv
module rad_return_mask
    import rad_pkg::*;
#(
    parameter int          ADDR_W     = 6,
    parameter int          DATA_W     = 32,
    parameter logic [2:0]  MODE_RESET = 3'b001,
    parameter logic [31:0] PAT_RESET  = 32'hA5C3_5A3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_mode_in,
    input  logic [DATA_W-1:0] cfg_pattern_in,
    output logic [2:0]        mode_rd,
    input  logic              trim_valid,
    input  logic [ADDR_W-1:0] trim_addr,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              rd_in_valid,
    input  logic [ADDR_W-1:0] rd_in_addr,
    input  logic [DATA_W-1:0] rd_in_data,
    output logic              rd_out_valid,
    output logic [DATA_W-1:0] rd_out_data
);
    typedef struct packed {
        logic              out_valid;
        logic [DATA_W-1:0] out_data;
        logic [2:0]        mode;
        logic [DATA_W-1:0] pattern;
    } state_t;

    state_t st_d, st_q;
    logic              hit_flag;
    logic [DATA_W-1:0] sel_data;

    rad_flag_table #(.ADDR_W(ADDR_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .trim_valid (trim_valid),
        .trim_addr  (trim_addr),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .look_addr  (rd_in_addr),
        .look_flag  (hit_flag)
    );

    rad_fill_select #(.DATA_W(DATA_W)) u_fill (
        .mode     (st_q.mode),
        .flagged  (hit_flag),
        .raw_data (rd_in_data),
        .pattern  (st_q.pattern),
        .ret_data (sel_data)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = rd_in_valid;
        if (rd_in_valid) st_d.out_data = sel_data;
        if (cfg_we) begin
            st_d.mode    = cfg_mode_in;
            st_d.pattern = cfg_pattern_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.out_valid <= 1'b0;
            st_q.out_data  <= '0;
            st_q.mode      <= MODE_RESET;
            st_q.pattern   <= DATA_W'(PAT_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_rd      = st_q.mode;
    assign rd_out_valid = st_q.out_valid;
    assign rd_out_data  = st_q.out_data;

    // R2: fixed single-cycle response
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_in_valid |=> rd_out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_in_valid |=> !rd_out_valid);

    // R3: unflagged reads pass through
    a_r3_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_in_valid && !hit_flag) |=> rd_out_data == $past(rd_in_data));

    // R5: zero fill
    a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_in_valid && hit_flag && st_q.mode == RM_ZERO) |=> rd_out_data == '0);

    // R6: pattern fill
    a_r6_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_in_valid && hit_flag && st_q.mode == RM_PATTERN)
            |=> rd_out_data == $past(st_q.pattern));

    // R11: configuration write is visible on readback
    a_r11_readback: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> mode_rd == $past(cfg_mode_in));
endmodule

// File: tb/tb_rad_return_mask.sv
module tb_rad_return_mask;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam logic [31:0] PAT = 32'h1234_ABCD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_mode_in = '0;
    logic [DW-1:0] cfg_pattern_in = '0;
    logic [2:0]    mode_rd;
    logic          trim_valid = 1'b0;
    logic [AW-1:0] trim_addr = '0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          rd_in_valid = 1'b0;
    logic [AW-1:0] rd_in_addr = '0;
    logic [DW-1:0] rd_in_data = '0;
    logic          rd_out_valid;
    logic [DW-1:0] rd_out_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    rad_return_mask dut (.*);

    // {mode[3], trim_first[1], addr[6], raw[32], expect[32]}
    localparam int VN = 10;
    localparam logic [73:0] VEC [VN] = '{
        {3'b001, 1'b0, 6'd3,  32'h1111_1111, 32'h1111_1111}, // R3
        {3'b001, 1'b1, 6'd3,  32'h1111_1111, 32'h0000_0000}, // R5
        {3'b010, 1'b1, 6'd4,  32'h2222_2222, PAT          }, // R6
        {3'b000, 1'b1, 6'd5,  32'h3333_3333, 32'h3333_3333}, // R7
        {3'b011, 1'b1, 6'd6,  32'h4444_4444, 32'h4444_4444}, // R8
        {3'b111, 1'b1, 6'd7,  32'h5555_5555, 32'h5555_5555}, // R8
        {3'b010, 1'b0, 6'd8,  32'h6666_6666, 32'h6666_6666}, // R3
        {3'b001, 1'b1, 6'd63, 32'hFFFF_FFFF, 32'h0000_0000}, // R5
        {3'b001, 1'b1, 6'd0,  32'h7777_7777, 32'h0000_0000}, // R5
        {3'b100, 1'b1, 6'd9,  32'h8888_8888, 32'h8888_8888}  // R8
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        cfg_we = 1'b1; cfg_mode_in = m; cfg_pattern_in = PAT;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_trim(input logic [AW-1:0] a);
        trim_valid = 1'b1; trim_addr = a;
        @(negedge clk);
        trim_valid = 1'b0;
    endtask

    task automatic do_write(input logic [AW-1:0] a);
        wr_valid = 1'b1; wr_addr = a;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] raw,
                           output logic [DW-1:0] got);
        rd_in_valid = 1'b1; rd_in_addr = a; rd_in_data = raw;
        @(negedge clk);
        rd_in_valid = 1'b0;
        got = rd_out_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] got, got2;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 mode readback", DW'(mode_rd), DW'(3'b001));
        check("R1 out valid", DW'(rd_out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(6'd2, 32'hCAFE_0002, got);
        check("R1 no flags after reset", got, 32'hCAFE_0002);

        // R11 configuration readback
        set_mode(3'b101);
        check("R11 readback", DW'(mode_rd), DW'(3'b101));

        // Vector table
        for (int i = 0; i < VN; i++) begin
            set_mode(VEC[i][73:71]);
            if (VEC[i][70]) do_trim(VEC[i][69:64]); // R4: read in the next cycle
            do_read(VEC[i][69:64], VEC[i][63:32], got);
            check($sformatf("R4 vector %0d", i), got, VEC[i][31:0]);
            do_write(VEC[i][69:64]);
        end

        // R6 repeated reads identical
        set_mode(3'b010);
        do_trim(6'd10);
        do_read(6'd10, 32'h0BAD_0001, got);
        do_read(6'd10, 32'h0BAD_0002, got2);
        check("R6 first read", got, PAT);
        check("R6 repeat identical", got2, got);

        // R9 write clears flag
        set_mode(3'b001);
        do_trim(6'd11);
        do_write(6'd11);
        do_read(6'd11, 32'hBEEF_0011, got);
        check("R9 write clears", got, 32'hBEEF_0011);

        // R10 same-cycle trim and write
        trim_valid = 1'b1; trim_addr = 6'd12; wr_valid = 1'b1; wr_addr = 6'd12;
        @(negedge clk);
        trim_valid = 1'b0; wr_valid = 1'b0;
        do_read(6'd12, 32'hBEEF_0012, got);
        check("R10 write wins", got, 32'hBEEF_0012);

        // R12 neighbours untouched
        do_trim(6'd13);
        do_read(6'd14, 32'hBEEF_0014, got);
        check("R12 neighbour not flagged", got, 32'hBEEF_0014);
        do_write(6'd15);
        do_read(6'd13, 32'hBEEF_0013, got);
        check("R12 flag kept", got, 32'h0);

        // R2 back-to-back ordered stream, then idle
        rd_in_valid = 1'b1; rd_in_addr = 6'd13; rd_in_data = 32'hAAAA_0001;
        @(negedge clk);
        check("R2 beat0 valid", DW'(rd_out_valid), 32'd1);
        check("R2 beat0 data", rd_out_data, 32'h0);
        rd_in_addr = 6'd14; rd_in_data = 32'hAAAA_0002;
        @(negedge clk);
        check("R2 beat1 data", rd_out_data, 32'hAAAA_0002);
        rd_in_addr = 6'd20; rd_in_data = 32'hAAAA_0003;
        @(negedge clk);
        check("R2 beat2 data", rd_out_data, 32'hAAAA_0003);
        rd_in_valid = 1'b0;
        @(negedge clk);
        check("R2 valid drops", DW'(rd_out_valid), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule